// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block is one bank of 32 general-purpose pins with a small memory-mapped register port. Software sets which pins drive their pads, which level they drive, and reads back the level seen on every pad. The driven levels live in one 32-bit output latch. Three registers can change that latch: a full-width read-write data register, and two write-only half-word registers. One half-word register covers pins 0..15 and the other covers pins 16..31.

Each half-word register packs a per-pin keep mask into its upper 16 bits and new levels into its lower 16 bits. A single store can therefore change any chosen group of pins in one half without a read-modify-write sequence. This matters when several agents share the same bank.

A pin drives its pad only when software has set both its direction bit and its output-enable bit. Pad levels pass through a two-stage synchronizer before any read sees them. The register port takes one request per cycle: a write takes effect at the clock edge that samples it, and read data is returned one cycle after the request.

Top module: `gpio_bank_masked`

## Requirements
- R1: After reset the output latch, direction register and output-enable register are all zero, so `padOut` and `padOe` are all zero and every pin is an input.
- R2: A write to the full data register (address 0x040) replaces all 32 latch bits. A read of 0x040 returns the latch.
- R3: A write to the low masked register (address 0x000) sets latch bit i (i < 16) to wdata[i] when wdata[16+i] is 0. It keeps latch bit i when wdata[16+i] is 1, and it never changes latch bits 16..31.
- R4: A write to the high masked register (address 0x004) sets latch bit 16+i to wdata[i] when wdata[16+i] is 0. It keeps latch bit 16+i when wdata[16+i] is 1, and it never changes latch bits 0..15.
- R5: A read of 0x000 returns latch bits 15..0 in rdata[15:0]. A read of 0x004 returns latch bits 31..16 in rdata[15:0]. In both cases rdata[31:16] reads 0.
- R6: The direction register (0x204) and the output-enable register (0x208) are full 32-bit read-write registers.
- R7: `padOe[i]` is 1 exactly when direction bit i and output-enable bit i are both 1. It follows a register write from the same clock edge.
- R8: `padOut` always equals the output latch, whatever the direction.
- R9: A read of 0x060 returns the pad levels after two synchronizer flops, whatever each pin's direction. A pad change set up before clock edge k is first returned by a read captured at edge k+2.
- R10: Read data appears in the cycle after the read request and is 0 in any cycle that follows no read. Reads of unmapped addresses return 0, and writes to unmapped addresses change nothing.
- R11: A write to the read-only pad register (0x060) changes no latch, direction or output-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regValid | input | 1 | Register request valid this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 10 | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, one cycle after a read request |
| padIn | input | 32 | Asynchronous pad levels |
| padOut | output | 32 | Level each pin drives when enabled |
| padOe | output | 32 | Per-pin tri-state enable, 1 = drive |

## Verification
The hardest case to reach from the ports is the synchronizer latency on the pad read. The stimulus changes `padIn` in the same half-cycle that it issues a read, then issues back-to-back reads. It expects the old level at the first two capture edges and the new level at the third. A synchronizer with one stage too few or too many fails this sequence.

Masked writes are exercised by a table. The table mixes fully masked, fully open and single-bit-open masks, in both halves. It checks that the opposite half of the latch is never disturbed.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Byte offsets of the bank registers
  localparam logic [11:0] ADDR_MASK_LO = 12'h000;
  localparam logic [11:0] ADDR_MASK_HI = 12'h004;
  localparam logic [11:0] ADDR_DATA    = 12'h040;
  localparam logic [11:0] ADDR_PAD     = 12'h060;
  localparam logic [11:0] ADDR_DIR     = 12'h204;
  localparam logic [11:0] ADDR_OEN     = 12'h208;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_LOW,
    RD_HIGH,
    RD_DATA,
    RD_PAD,
    RD_DIR,
    RD_OEN
  } rdSel_e;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic   wrLow;
    logic   wrHigh;
    logic   wrData;
    logic   wrDir;
    logic   wrOen;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          regValid,
  input  logic          regWrite,
  input  logic [AW-1:0] regAddr,
  output regStrobe_t    stb
);

  localparam logic [AW-1:0] A_LO   = AW'(ADDR_MASK_LO);
  localparam logic [AW-1:0] A_HI   = AW'(ADDR_MASK_HI);
  localparam logic [AW-1:0] A_DATA = AW'(ADDR_DATA);
  localparam logic [AW-1:0] A_PAD  = AW'(ADDR_PAD);
  localparam logic [AW-1:0] A_DIR  = AW'(ADDR_DIR);
  localparam logic [AW-1:0] A_OEN  = AW'(ADDR_OEN);

  logic isWr;
  logic isRd;

  assign isWr = regValid && regWrite;
  assign isRd = regValid && !regWrite;

  // Write decode: the pad register is read-only, so no write strobe for it
  always_comb begin
    stb.wrLow  = isWr && (regAddr == A_LO);
    stb.wrHigh = isWr && (regAddr == A_HI);
    stb.wrData = isWr && (regAddr == A_DATA);
    stb.wrDir  = isWr && (regAddr == A_DIR);
    stb.wrOen  = isWr && (regAddr == A_OEN);
  end

  // Read decode: unmapped addresses select nothing and read as zero
  always_comb begin
    stb.rdSel = RD_NONE;
    if (isRd) begin
      unique case (regAddr)
        A_LO:    stb.rdSel = RD_LOW;
        A_HI:    stb.rdSel = RD_HIGH;
        A_DATA:  stb.rdSel = RD_DATA;
        A_PAD:   stb.rdSel = RD_PAD;
        A_DIR:   stb.rdSel = RD_DIR;
        A_OEN:   stb.rdSel = RD_OEN;
        default: stb.rdSel = RD_NONE;
      endcase
    end
  end

  // R10: at most one write strobe fires per request
  always_comb begin
    assert ($onehot0({stb.wrLow, stb.wrHigh, stb.wrData, stb.wrDir, stb.wrOen}))
      else $error("p_single_strobe_r10");
  end

endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  regStrobe_t    stb,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  input  logic [DW-1:0] padIn,
  output logic [DW-1:0] padOut,
  output logic [DW-1:0] padOe
);

  localparam int HALF  = DW / 2;
  localparam int LANES = 2;

  logic [DW-1:0] outLatch;
  logic [DW-1:0] dirReg;
  logic [DW-1:0] oenReg;
  logic [DW-1:0] nextLatch;
  logic [DW-1:0] syncStage [SYNC_STAGES];
  logic [DW-1:0] padSync;
  logic [DW-1:0] rdNext;

  logic [HALF-1:0] laneNew [LANES];
  logic [HALF-1:0] keepMask;
  logic [HALF-1:0] newBits;

  assign keepMask = regWdata[DW-1:HALF];
  assign newBits  = regWdata[HALF-1:0];

  // One masked-merge lane per half of the latch
  for (genvar h = 0; h < LANES; h++) begin : g_lane
    logic [HALF-1:0] laneCur;
    logic            laneWr;
    assign laneCur    = outLatch[h*HALF +: HALF];
    assign laneWr     = (h == 0) ? stb.wrLow : stb.wrHigh;
    assign laneNew[h] = laneWr ? ((laneCur & keepMask) | (newBits & ~keepMask))
                               : laneCur;
  end

  assign nextLatch = stb.wrData ? regWdata : {laneNew[1], laneNew[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outLatch <= '0;
      dirReg   <= '0;
      oenReg   <= '0;
    end else begin
      outLatch <= nextLatch;
      if (stb.wrDir) dirReg <= regWdata;
      if (stb.wrOen) oenReg <= regWdata;
    end
  end

  // Pad synchronizer chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) syncStage[k] <= '0;
    end else begin
      syncStage[0] <= padIn;
      for (int k = 1; k < SYNC_STAGES; k++) syncStage[k] <= syncStage[k-1];
    end
  end

  assign padSync = syncStage[SYNC_STAGES-1];

  // Registered read mux
  always_comb begin
    unique case (stb.rdSel)
      RD_LOW:  rdNext = {{(DW-HALF){1'b0}}, outLatch[HALF-1:0]};
      RD_HIGH: rdNext = {{(DW-HALF){1'b0}}, outLatch[DW-1:HALF]};
      RD_DATA: rdNext = outLatch;
      RD_PAD:  rdNext = padSync;
      RD_DIR:  rdNext = dirReg;
      RD_OEN:  rdNext = oenReg;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regRdata <= '0;
    else        regRdata <= rdNext;
  end

  assign padOut = outLatch;
  assign padOe  = dirReg & oenReg;

  p_low_keeps_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrLow |=> outLatch[DW-1:HALF] == $past(outLatch[DW-1:HALF]));

  p_low_mask_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrLow |=> ((outLatch[HALF-1:0] ^ $past(outLatch[HALF-1:0]))
                   & $past(regWdata[DW-1:HALF])) == '0);

  p_high_keeps_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrHigh |=> outLatch[HALF-1:0] == $past(outLatch[HALF-1:0]));

  p_high_mask_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrHigh |=> ((outLatch[DW-1:HALF] ^ $past(outLatch[DW-1:HALF]))
                    & $past(regWdata[DW-1:HALF])) == '0);

  p_idle_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.wrLow || stb.wrHigh || stb.wrData) |=> $stable(padOut));

  p_oe_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.wrDir || stb.wrOen) |=> $stable(padOe));

  p_read_gap_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdSel == RD_NONE) |=> regRdata == '0);

endmodule

// File: rtl/gpio_bank_masked.sv
module gpio_bank_masked
  import gpio_bank_pkg::*;
#(
  parameter int AW          = 10,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          regValid,
  input  logic          regWrite,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  input  logic [DW-1:0] padIn,
  output logic [DW-1:0] padOut,
  output logic [DW-1:0] padOe
);

  regStrobe_t stb;

  gpio_bank_ctrl #(.AW(AW)) u_ctrl (
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .stb      (stb)
  );

  gpio_bank_datapath #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe)
  );

endmodule

// File: tb/gpio_bank_masked_test.sv
`timescale 1ns/1ps
module gpio_bank_masked_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [9:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] padIn = '0;
  logic [31:0] padOut;
  logic [31:0] padOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_bank_masked uut (
    .clk(clk), .rst_n(rst_n), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  // Vector table: address, write data, expected latch afterwards
  localparam int NV = 9;
  localparam logic [9:0] VA [NV] = '{
    10'h040, 10'h000, 10'h004, 10'h000, 10'h004,
    10'h000, 10'h060, 10'h100, 10'h040 };
  localparam logic [31:0] VD [NV] = '{
    32'hA5A5_5A5A, 32'hFF00_00FF, 32'h0000_1234, 32'hFFFF_0000, 32'hFFFE_0001,
    32'h7FFF_8000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000 };
  localparam logic [31:0] VE [NV] = '{
    32'hA5A5_5A5A, 32'hA5A5_5AFF, 32'h1234_5AFF, 32'h1234_5AFF, 32'h1235_5AFF,
    32'h1235_DAFF, 32'h1235_DAFF, 32'h1235_DAFF, 32'h0000_0000 };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    @(negedge clk);
    d = regRdata;
    regValid = 1'b0;
  endtask

  function automatic string tagFor(input logic [9:0] a);
    case (a)
      10'h000: return "R3";
      10'h004: return "R4";
      10'h040: return "R2";
      10'h060: return "R11";
      default: return "R10";
    endcase
  endfunction

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 padOut", padOut, 32'h0);
    check("R1 padOe", padOe, 32'h0);
    rd(10'h204, r); check("R1 dir", r, 32'h0);
    rd(10'h208, r); check("R1 oen", r, 32'h0);
    rd(10'h040, r); check("R1 latch", r, 32'h0);

    // Table walk: writes through all three data paths
    for (int v = 0; v < NV; v++) begin
      wr(VA[v], VD[v]);
      check({tagFor(VA[v]), " R8 padOut"}, padOut, VE[v]);
      rd(10'h040, r); check({tagFor(VA[v]), " data readback"}, r, VE[v]);
      rd(10'h000, r); check("R5 low view", r, {16'h0, VE[v][15:0]});
      rd(10'h004, r); check("R5 high view", r, {16'h0, VE[v][31:16]});
    end

    // R6 / R7 direction and output enable
    wr(10'h204, 32'hF0F0_00FF);
    wr(10'h208, 32'h0FF0_0F0F);
    check("R7 padOe", padOe, 32'h00F0_000F);
    rd(10'h204, r); check("R6 dir", r, 32'hF0F0_00FF);
    rd(10'h208, r); check("R6 oen", r, 32'h0FF0_0F0F);
    wr(10'h060, 32'h0);
    check("R11 padOe after RO write", padOe, 32'h00F0_000F);

    // R10 read gap and unmapped read
    rd(10'h204, r);
    @(negedge clk);
    check("R10 idle rdata", regRdata, 32'h0);
    rd(10'h3F0, r); check("R10 unmapped read", r, 32'h0);

    // R9 synchronizer latency, all pins outputs
    wr(10'h204, 32'hFFFF_FFFF);
    padIn = 32'h1357_9BDF;
    rd(10'h060, r); check("R9 first edge old", r, 32'h0);
    rd(10'h060, r); check("R9 second edge old", r, 32'h0);
    rd(10'h060, r); check("R9 third edge new", r, 32'h1357_9BDF);
    check("R8 padOut unaffected by pads", padOut, 32'h0);

    // R9 with all pins inputs
    wr(10'h204, 32'h0);
    padIn = 32'h2468_ACE0;
    repeat (3) @(negedge clk);
    rd(10'h060, r); check("R9 input pins", r, 32'h2468_ACE0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule